// File: doc/BRIEF.md
# Last Branch Record Capture Unit

This unit keeps a trace of where execution most recently jumped. Each time the upstream pipeline reports a taken control transfer, the unit stores its source and destination address. Each time it reports an exception or interrupt transfer, the unit stores that source and destination pair in a second, separate record. Upstream logic decides what counts as a transfer. Taken branches, calls, returns, loop branches, far transfers, software interrupts, exceptions and interrupt returns are all reported on one of the two event inputs.

A debug-control register has two bits. One arms the recording. The other selects branch-step mode, in which the trap logic single-steps on transfers rather than on every instruction. Entering the debug trap disarms recording in hardware, so the four address records stay frozen for the handler to inspect. A transfer that arrives in the same cycle as the trap entry is still stored. Software restarts capture by writing the arm bit to 1 again. The four records are read-only; a write to their addresses changes nothing.

Register addresses on the access port: 0 is the control register (bit 0 arms recording, bit 1 selects branch-step mode, all other bits read 0). 1 is the transfer source, 2 the transfer destination, 3 the exception source and 4 the exception destination. Addresses 5 to 7 read 0.

Top module: `lbr_capture_top`

## Requirements
- R1: After reset, the control register and all four address records read 0.
- R2: A write to address 0 sets the arm bit from wr_data bit 0 and the branch-step bit from wr_data bit 1, visible one cycle later. Reading address 0 returns arm in bit 0 and branch-step in bit 1, with zeros above.
- R3: While armed, a transfer event stores its source at address 1 and its destination at address 2, readable in the cycle after the event.
- R4: While armed, an exception event stores its source at address 3 and its destination at address 4, and leaves addresses 1 and 2 unchanged. A transfer event and an exception event in the same cycle are both stored.
- R5: While disarmed, transfer and exception events change no record.
- R6: Trap entry clears the arm bit in the next cycle and leaves the branch-step bit and all records unchanged.
- R7: A transfer or exception event in the same cycle as trap entry is still stored, because the arm state before the trap applies.
- R8: If trap entry and a control write happen in the same cycle, the arm bit ends at 0 and the branch-step bit takes the written value.
- R9: Writes to addresses 1 to 4 are ignored, and so are writes to any address other than 0.
- R10: Reads of addresses 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_fire | input | 1 | Taken control-transfer strobe |
| br_from | input | XW | Source address of the transfer |
| br_to | input | XW | Destination address of the transfer |
| exc_fire | input | 1 | Exception/interrupt transfer strobe |
| exc_from | input | XW | Source address of the exception transfer |
| exc_to | input | XW | Destination address of the exception transfer |
| trap_enter | input | 1 | Debug trap is being entered |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 2 | Write data (control bits) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | XW | Read data, combinational from rd_addr |
| rec_armed | output | 1 | Current arm bit |
| step_on_xfer | output | 1 | Current branch-step bit, for the trap logic |

## Verification
Two functions can fall in the same cycle: trap entry together with a transfer or exception capture, and trap entry together with a software write to the control register. The bench drives these on the same clock edge: a transfer and an exception are strobed together with trap_enter, and in a separate cycle a control write that re-arms is issued together with trap_enter. The result is judged at the access port one cycle later. The coincident addresses must be present in the records. The arm bit must read 0 while the branch-step bit carries the written value. A transfer issued after that must not disturb the records.

// File: rtl/lbr_pkg.sv
// Package: shared register addresses and the control-register layout for
// the last-branch-record capture unit. Assumes a 3-bit register address.
package lbr_pkg;
    localparam int REG_AW = 3;
    localparam int CTL_W  = 2;

    typedef enum logic [REG_AW-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_BR_SRC = 3'd1,
        SEL_BR_DST = 3'd2,
        SEL_EX_SRC = 3'd3,
        SEL_EX_DST = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic step_on_xfer;
        logic rec_on;
    } dbgctl_t;
endpackage

// File: rtl/lbr_ctl_reg.sv
// Module: debug-control register. Holds the arm bit and the branch-step bit.
// A software write loads both bits. Trap entry clears only the arm bit and
// wins over a write in the same cycle. Assumes wr_hit is already decoded.
module lbr_ctl_reg
    import lbr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_hit,
    input  logic    wr_rec,
    input  logic    wr_step,
    input  logic    trap_enter,
    output dbgctl_t ctl
);

    // Register update: software load first, hardware disarm overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (wr_hit) begin
                ctl.rec_on       <= wr_rec;
                ctl.step_on_xfer <= wr_step;
            end
            if (trap_enter) begin
                ctl.rec_on <= 1'b0;
            end
        end
    end

    // R6
    trap_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> !ctl.rec_on);

    // R6
    trap_keeps_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_enter && !wr_hit) |=> ctl.step_on_xfer == $past(ctl.step_on_xfer));

    // R8
    trap_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_enter && wr_hit) |=> (!ctl.rec_on && ctl.step_on_xfer == $past(wr_step)));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !trap_enter) |=> (ctl.rec_on == $past(wr_rec) &&
                                     ctl.step_on_xfer == $past(wr_step)));

endmodule

// File: rtl/lbr_rec_pair.sv
// Module: one source/destination record pair. Loads both addresses when
// the unit is armed and an event strobe arrives. Otherwise it holds.
// Assumes 'arm' is the arm state before any same-cycle trap entry.
module lbr_rec_pair #(
    parameter int XW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          ev,
    input  logic [XW-1:0] src,
    input  logic [XW-1:0] dst,
    output logic [XW-1:0] from_q,
    output logic [XW-1:0] to_q
);

    logic take;
    // Capture qualifier.
    always_comb take = arm && ev;

    // Record storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            from_q <= '0;
            to_q   <= '0;
        end else if (take) begin
            from_q <= src;
            to_q   <= dst;
        end
    end

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && ev) |=> (from_q == $past(src) && to_q == $past(dst)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm && ev) |=> ($stable(from_q) && $stable(to_q)));

endmodule

// File: rtl/lbr_rd_mux.sv
// Module: read-side selector. Returns the control bits zero-extended at
// address 0, the four records at addresses 1 to 4, and zero elsewhere.
module lbr_rd_mux
    import lbr_pkg::*;
#(
    parameter int XW = 64
) (
    input  logic [REG_AW-1:0] sel,
    input  dbgctl_t           ctl,
    input  logic [XW-1:0]     br_src,
    input  logic [XW-1:0]     br_dst,
    input  logic [XW-1:0]     ex_src,
    input  logic [XW-1:0]     ex_dst,
    output logic [XW-1:0]     rdata
);

    // Address decode for reads.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL:   rdata[CTL_W-1:0] = ctl;
            SEL_BR_SRC: rdata = br_src;
            SEL_BR_DST: rdata = br_dst;
            SEL_EX_SRC: rdata = ex_src;
            SEL_EX_DST: rdata = ex_dst;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/lbr_capture_top.sv
// Module: last-branch-record capture unit top. It ties the control register,
// two record pairs (transfer and exception, built by a generate loop) and
// the read selector together. Record addresses accept no writes.
module lbr_capture_top
    import lbr_pkg::*;
#(
    parameter int XW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_fire,
    input  logic [XW-1:0]     br_from,
    input  logic [XW-1:0]     br_to,
    input  logic              exc_fire,
    input  logic [XW-1:0]     exc_from,
    input  logic [XW-1:0]     exc_to,
    input  logic              trap_enter,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [XW-1:0]     rd_data,
    output logic              rec_armed,
    output logic              step_on_xfer
);

    localparam int NPAIR = 2;

    dbgctl_t       ctl;
    logic          ctl_hit;
    logic          ev_v   [NPAIR];
    logic [XW-1:0] ev_src [NPAIR];
    logic [XW-1:0] ev_dst [NPAIR];
    logic [XW-1:0] rec_f  [NPAIR];
    logic [XW-1:0] rec_t  [NPAIR];

    // Write decode: only the control address accepts writes.
    always_comb ctl_hit = wr_en && (wr_addr == SEL_CTRL);

    // Event routing: index 0 is transfers, index 1 is exceptions.
    always_comb begin
        ev_v[0]   = br_fire;
        ev_src[0] = br_from;
        ev_dst[0] = br_to;
        ev_v[1]   = exc_fire;
        ev_src[1] = exc_from;
        ev_dst[1] = exc_to;
    end

    lbr_ctl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (ctl_hit),
        .wr_rec     (wr_data[0]),
        .wr_step    (wr_data[1]),
        .trap_enter (trap_enter),
        .ctl        (ctl)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        lbr_rec_pair #(.XW(XW)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm    (ctl.rec_on),
            .ev     (ev_v[g]),
            .src    (ev_src[g]),
            .dst    (ev_dst[g]),
            .from_q (rec_f[g]),
            .to_q   (rec_t[g])
        );
    end

    lbr_rd_mux #(.XW(XW)) u_rd (
        .sel    (rd_addr),
        .ctl    (ctl),
        .br_src (rec_f[0]),
        .br_dst (rec_t[0]),
        .ex_src (rec_f[1]),
        .ex_dst (rec_t[1]),
        .rdata  (rd_data)
    );

    // Status outputs for the trap logic.
    always_comb begin
        rec_armed    = ctl.rec_on;
        step_on_xfer = ctl.step_on_xfer;
    end

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > 3'd4) |-> (rd_data == '0));

    // R9
    rec_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 3'd0 && !br_fire && !exc_fire) |=>
            ($stable(rec_f[0]) && $stable(rec_t[1])));

    // R4
    exc_spares_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_fire && !br_fire) |=> ($stable(rec_f[0]) && $stable(rec_t[0])));

    // R7
    trap_same_cycle_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_enter && rec_armed && br_fire) |=> (rec_f[0] == $past(br_from)));

endmodule

// File: tb/lbr_capture_top_bench.sv
// Scoreboard bench: the driver updates a reference model and pushes the
// expected read values into a queue. The monitor pops each entry and compares
// it with rd_data between clock edges.
module lbr_capture_top_bench;
    localparam int XW = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          br_fire, exc_fire, trap_enter, wr_en;
    logic [XW-1:0] br_from, br_to, exc_from, exc_to;
    logic [2:0]    wr_addr, rd_addr;
    logic [1:0]    wr_data;
    logic [XW-1:0] rd_data;
    logic          rec_armed, step_on_xfer;

    always #5 clk = ~clk;

    lbr_capture_top #(.XW(XW)) u_lbr_capture_top (
        .clk(clk), .rst_n(rst_n),
        .br_fire(br_fire), .br_from(br_from), .br_to(br_to),
        .exc_fire(exc_fire), .exc_from(exc_from), .exc_to(exc_to),
        .trap_enter(trap_enter),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .rec_armed(rec_armed), .step_on_xfer(step_on_xfer)
    );

    typedef struct {
        logic [XW-1:0] exp;
        string         tag;
        int            addr;
    } sb_item_t;

    sb_item_t      sb_q[$];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 0;

    // reference model
    logic          m_arm, m_step;
    logic [XW-1:0] m_rec[5];

    function automatic logic [XW-1:0] model_read(int a);
        if (a == 0) return {{(XW-2){1'b0}}, m_step, m_arm};
        if (a >= 1 && a <= 4) return m_rec[a];
        return '0;
    endfunction

    // one cycle of stimulus. The model follows the requirements R2 to R9.
    task automatic cycle(input bit b, input logic [XW-1:0] bf, input logic [XW-1:0] bt,
                         input bit e, input logic [XW-1:0] ef, input logic [XW-1:0] et,
                         input bit tr, input bit w, input logic [2:0] wa, input logic [1:0] wd);
        @(negedge clk);
        br_fire = b;  br_from = bf;  br_to = bt;
        exc_fire = e; exc_from = ef; exc_to = et;
        trap_enter = tr; wr_en = w; wr_addr = wa; wr_data = wd;
        if (m_arm && b) begin m_rec[1] = bf; m_rec[2] = bt; end
        if (m_arm && e) begin m_rec[3] = ef; m_rec[4] = et; end
        if (w && wa == 3'd0) begin m_arm = wd[0]; m_step = wd[1]; end
        if (tr) m_arm = 1'b0;
        @(negedge clk);
        br_fire = 0; exc_fire = 0; trap_enter = 0; wr_en = 0;
    endtask

    task automatic expect_reg(input int a, input string tag);
        sb_item_t it;
        @(negedge clk);
        rd_addr = 3'(a);
        it.exp = model_read(a); it.tag = tag; it.addr = a;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_all(input string tag);
        for (int a = 0; a < 5; a++) expect_reg(a, tag);
    endtask

    // monitor: compares queued expectations between clock edges
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr %0d: actual %h expected %h",
                             it.tag, it.addr, rd_data, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; br_fire = 0; exc_fire = 0; trap_enter = 0; wr_en = 0;
        br_from = '0; br_to = '0; exc_from = '0; exc_to = '0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        m_arm = 0; m_step = 0;
        for (int i = 0; i < 5; i++) m_rec[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        expect_all("R1");
        // R5 event while disarmed
        cycle(1, 64'h1111_0000_0000_1000, 64'h1111_0000_0000_2000,
              1, 64'h2222_0000_0000_0010, 64'h2222_0000_0000_0020, 0, 0, 0, 0);
        expect_all("R5");
        // R2 arm via control write
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 2'b01);
        expect_reg(0, "R2");
        // R3 transfer captured
        cycle(1, 64'h0000_7FFF_0040_1235, 64'h0000_7FFF_0040_9000, 0, 0, 0, 0, 0, 0, 0);
        expect_all("R3");
        // R4 exception keeps transfer records
        cycle(0, 0, 0, 1, 64'hFFFF_8000_0000_0100, 64'hFFFF_8000_0000_0E00, 0, 0, 0, 0);
        expect_all("R4");
        // R4 both in one cycle
        cycle(1, 64'hA5A5_A5A5_0000_0001, 64'h5A5A_5A5A_0000_0002,
              1, 64'hC3C3_0000_0000_0003, 64'h3C3C_0000_0000_0004, 0, 0, 0, 0);
        expect_all("R4");
        // R9 writes to record addresses and to unmapped addresses ignored
        for (int a = 1; a < 8; a++) cycle(0, 0, 0, 0, 0, 0, 0, 1, 3'(a), 2'b10);
        expect_all("R9");
        // R7 trap with coincident events: captured, then R6 disarm
        cycle(1, 64'hDEAD_0000_0000_0B01, 64'hBEEF_0000_0000_0B02,
              1, 64'hDEAD_0000_0000_0E01, 64'hBEEF_0000_0000_0E02, 1, 0, 0, 0);
        expect_all("R7");
        expect_reg(0, "R6");
        // R6 frozen after trap
        cycle(1, 64'h1, 64'h2, 1, 64'h3, 64'h4, 0, 0, 0, 0);
        expect_all("R6");
        // R2 re-arm with branch-step, then R6 trap keeps step bit
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 2'b11);
        expect_reg(0, "R2");
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        expect_reg(0, "R6");
        // R8 trap and re-arm write together: arm stays 0, step written
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 2'b00);
        cycle(0, 0, 0, 0, 0, 0, 1, 1, 3'd0, 2'b11);
        expect_reg(0, "R8");
        cycle(1, 64'h77, 64'h88, 0, 0, 0, 0, 0, 0, 0);
        expect_all("R8");
        // R3 re-arm restores capture
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 2'b01);
        cycle(1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0, 0, 0, 0, 0, 0, 0);
        expect_all("R3");
        // R10 unmapped reads
        for (int a = 5; a < 8; a++) expect_reg(a, "R10");

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule